// File: doc/BRIEF.md
# Conversion-Start Synchronizer with Bus Lockout

This block is the digital host-side control of a sampling converter. An active-low start strobe arrives with no relation to the converter clock. It passes through a flop synchronizer, and from it the block makes a registered, active-low busy flag. While busy is low the track/hold is settling, and host traffic on the data bus could disturb the held sample.

A one-bit control register, the lockout enable, selects between two host policies. With the bit clear, the result drivers stay off while busy is low. Writes to the control register are also refused during that time. Any access with chip-select low raises a wait request, so the host stretches its cycle until busy returns high. With the bit set, reads and writes go through at once and no wait is ever raised. The bit sits at position 5 of the host data bus, a position given by the `LOCK_BIT` parameter.

Top module: `cvt_start_gate`

## Requirements
- R1: While reset is asserted and after it is released, `busy_n` is 1, `wait_req` is 0, `data_oe` is 0, and the lockout bit is 0, which means lockout is in force.
- R2: After `convst_n` is driven low ahead of clock edge E0, `busy_n` first reads 0 after edge E0+2. This delay is two synchronizer stages plus the busy register.
- R3: A `convst_n` low pulse of W clock cycles (W from 1 to 4) keeps `busy_n` low for exactly W+1 cycles. `busy_n` rises on the second edge after the synchronized strobe is seen high. The low time never exceeds W+2 cycles.
- R4: With the lockout bit at 0, `data_oe` is 0 whenever `busy_n` is 0, even when `cs_n` and `rd_n` are both low.
- R5: With the lockout bit at 1, a read (`cs_n`=0, `rd_n`=0) during busy drives `data_oe`=1 and `data_o`=`result`.
- R6: With the lockout bit at 0, `wait_req` is 1 exactly while `cs_n` is 0 and `busy_n` is 0. In the cycle `busy_n` returns high, `wait_req` drops and a pending read drives `result`.
- R7: With the lockout bit at 1, `wait_req` stays 0 during a busy pulse even with `cs_n` low.
- R8: A write (`cs_n`=0, `wr_n`=0) loads the lockout bit from `data_i[5]` on the next clock edge. While `busy_n` is 0 and the bit is 0, the write is held off. A write still held when busy ends completes on the next edge.
- R9: With busy high, a read drives `data_oe`=1 and `data_o`=`result`. Without a read, `data_oe` is 0 and `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst_n | input | 1 | Asynchronous active-low conversion-start strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| result | input | 12 | Conversion result to be read |
| data_i | input | 12 | Host write data; bit 5 is the lockout bit |
| data_o | output | 12 | Result driven to host, zero when not driving |
| data_oe | output | 1 | Data bus drive enable |
| busy_n | output | 1 | Active-low busy, synchronous to clk |
| wait_req | output | 1 | Request to stretch the host access |

## Verification
The assertions assume that `cs_n`, `rd_n`, `wr_n` and `data_i` change only between clock edges and meet setup to the converter clock. They also assume that `convst_n`, however asynchronous, is seen through the synchronizer alone. The bench drives every input on the falling clock edge and samples on the falling edge too. This keeps host strobes away from the active edge. Start pulses are whole clock cycles of 1 to 4, so the expected busy window can be counted edge by edge.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
   // Host access decoded from the active-low strobes
   typedef struct packed {
      logic rd;
      logic wr;
      logic sel;
   } host_req_t;

   function automatic host_req_t decode_host(input logic cs_n, input logic rd_n,
                                             input logic wr_n);
      host_req_t r;
      r.sel = ~cs_n;
      r.rd  = ~cs_n & ~rd_n;
      r.wr  = ~cs_n & ~wr_n;
      return r;
   endfunction
endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cvt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cvt_busy.sv
module cvt_busy #(
   parameter int RELEASE_EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n_s,
   output logic busy_n
);
   localparam int CNT_W = (RELEASE_EDGES < 2) ? 1 : $clog2(RELEASE_EDGES);

   if (RELEASE_EDGES < 1) begin : g_bad_release
      $error("cvt_busy: RELEASE_EDGES must be at least 1");
   end

   logic             busy_q;
   logic [CNT_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         hi_cnt <= '0;
      end else if (!start_n_s) begin
         busy_q <= 1'b0;
         hi_cnt <= '0;
      end else if (!busy_q) begin
         if (hi_cnt == CNT_W'(RELEASE_EDGES - 1)) busy_q <= 1'b1;
         else                                     hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assign busy_n = busy_q;

   // R2: a synchronized low start always shows as busy one edge later
   p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_n_s |=> !busy_n);

   // R3: busy releases only after the strobe has been high for two sampled edges
   p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> ($past(start_n_s) && $past(start_n_s, 2)));
endmodule

// File: rtl/cvt_bus_gate.sv
module cvt_bus_gate
   import cvt_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int LOCK_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  host_req_t         req,
   input  logic              busy_n,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   output logic              wait_req
);
   if (LOCK_BIT >= DATA_W) begin : g_bad_lock_bit
      $error("cvt_bus_gate: LOCK_BIT must lie inside the data bus");
   end

   logic allow_q;      // 1 = bus open during busy, 0 = lockout
   logic access_ok;
   logic wr_go;
   logic wdata_unused;

   assign wdata_unused = ^data_i;
   assign access_ok    = busy_n | allow_q;
   assign wr_go        = req.wr & access_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     allow_q <= 1'b0;
      else if (wr_go) allow_q <= data_i[LOCK_BIT];
   end

   assign data_oe  = req.rd & access_ok;
   assign data_o   = data_oe ? result : '0;
   assign wait_req = req.sel & ~busy_n & ~allow_q;

   // R4: no drive while busy under lockout
   p_no_drive_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && !allow_q) |-> !data_oe);

   // R6: the stretch ends together with busy
   p_wait_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> !wait_req);

   // R8: a write during busy under lockout leaves the control bit untouched
   p_write_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && !allow_q && req.wr) |=> $stable(allow_q));

   // R5: when the bus is open, a read is never refused
   p_open_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (allow_q && req.rd) |-> data_oe);
endmodule

// File: rtl/cvt_start_gate.sv
module cvt_start_gate
   import cvt_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int LOCK_BIT      = 5,
   parameter int SYNC_STAGES   = 2,
   parameter int RELEASE_EDGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              convst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   output logic              busy_n,
   output logic              wait_req
);
   logic      start_n_s;
   host_req_t req;

   assign req = decode_host(cs_n, rd_n, wr_n);

   cvt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (convst_n),
      .sync_o  (start_n_s)
   );

   cvt_busy #(.RELEASE_EDGES(RELEASE_EDGES)) u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_n_s (start_n_s),
      .busy_n    (busy_n)
   );

   cvt_bus_gate #(.DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .busy_n   (busy_n),
      .result   (result),
      .data_i   (data_i),
      .data_o   (data_o),
      .data_oe  (data_oe),
      .wait_req (wait_req)
   );

   // R1: out of reset the block is idle with no drive and no stretch
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (busy_n && !wait_req));
endmodule

// File: tb/sim_cvt_start_gate.sv
module sim_cvt_start_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        convst_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [11:0] result = 12'hA5C, data_i = 12'h000;
   logic [11:0] data_o;
   logic        data_oe, busy_n, wait_req;
   int          n_run = 0, n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   cvt_start_gate u0 (.clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cs_n(cs_n),
      .rd_n(rd_n), .wr_n(wr_n), .result(result), .data_i(data_i), .data_o(data_o),
      .data_oe(data_oe), .busy_n(busy_n), .wait_req(wait_req));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_lock(input bit v);
      @(negedge clk); cs_n = 0; wr_n = 0; data_i = 12'(v) << 5;
      @(negedge clk); cs_n = 1; wr_n = 1; data_i = 0;
   endtask

   // R1
   task automatic t_reset();
      check(busy_n === 1'b1, "R1 busy_n", busy_n, 1);
      check(wait_req === 1'b0, "R1 wait_req", wait_req, 0);
      check(data_oe === 1'b0, "R1 data_oe", data_oe, 0);
      // lockout in force: a read during busy is not driven
      @(negedge clk); convst_n = 0; cs_n = 0; rd_n = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk); if (k == 2) convst_n = 1;
         if (k == 4) check(data_oe === 1'b0 && wait_req === 1'b1, "R1 lock reset 0",
                           {data_oe, wait_req}, 1);
      end
      cs_n = 1; rd_n = 1;
   endtask

   // R2 and R3: busy window for a W-cycle strobe
   task automatic t_busy_width(input int w);
      int first = 0, lows = 0, bad = 0;
      @(negedge clk); convst_n = 0;
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk); if (k == w) convst_n = 1;
         if (!busy_n) begin lows++; if (first == 0) first = k; end
         if ((busy_n === 1'b0) != (k >= 3 && k <= w + 3)) bad++;
      end
      check(first == 3, $sformatf("R2 first low sample w=%0d", w), first, 3);
      check(lows == w + 1 && bad == 0, $sformatf("R3 low cycles w=%0d", w), lows, w + 1);
   endtask

   // R4 and R6: read with lockout, host stretched
   task automatic t_locked_read(input int w);
      int waits = 0, drv_busy = 0, bad_wait = 0;
      bit got = 0;
      @(negedge clk); convst_n = 0; cs_n = 0; rd_n = 0; result = 12'h3C0 + 12'(w);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk); if (k == w) convst_n = 1;
         if (wait_req) waits++;
         if (!busy_n && data_oe) drv_busy++;
         if (wait_req !== !busy_n) bad_wait++;
         if (k == w + 4) got = (data_oe === 1'b1 && data_o === result);
      end
      cs_n = 1; rd_n = 1;
      check(drv_busy == 0, $sformatf("R4 drive during busy w=%0d", w), drv_busy, 0);
      check(waits == w + 1 && bad_wait == 0, $sformatf("R6 wait cycles w=%0d", w), waits, w + 1);
      check(got, "R6 read completes after release", data_o, result);
   endtask

   // R5 and R7: bus open during busy
   task automatic t_open_read();
      int waits = 0, miss = 0;
      @(negedge clk); convst_n = 0; cs_n = 0; rd_n = 0; result = 12'h5A3;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk); if (k == 3) convst_n = 1;
         if (wait_req) waits++;
         if (!busy_n && !(data_oe === 1'b1 && data_o === result)) miss++;
      end
      cs_n = 1; rd_n = 1;
      check(miss == 0, "R5 read during busy", miss, 0);
      check(waits == 0, "R7 no wait when open", waits, 0);
   endtask

   // R8: write under lockout is held off, then completes after busy
   task automatic t_write_hold();
      bit in_busy;
      @(negedge clk); convst_n = 0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk); if (k == 4) convst_n = 1;
      end
      // busy is low now: a one-cycle write must be ignored
      cs_n = 0; wr_n = 0; data_i = 12'h020;
      @(negedge clk); in_busy = !busy_n; cs_n = 1; wr_n = 1; data_i = 0;
      repeat (6) @(negedge clk);
      // probe lock bit: read during a new pulse must still be blocked
      @(negedge clk); convst_n = 0; cs_n = 0; rd_n = 0;
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk); if (k == 2) convst_n = 1;
         if (k == 4) check(in_busy && data_oe === 1'b0 && wait_req === 1'b1,
                           "R8 write in busy ignored", {data_oe, wait_req}, 1);
      end
      rd_n = 1;
      // held write across busy: completes once busy rises
      @(negedge clk); convst_n = 0; wr_n = 0; data_i = 12'h020;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk); if (k == 2) convst_n = 1;
      end
      cs_n = 1; wr_n = 1; data_i = 0;
      @(negedge clk); convst_n = 0; cs_n = 0; rd_n = 0;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk); if (k == 2) convst_n = 1;
         if (k == 4) check(data_oe === 1'b1 && wait_req === 1'b0,
                           "R8 held write completes", {data_oe, wait_req}, 2);
      end
      cs_n = 1; rd_n = 1;
      repeat (4) @(negedge clk);
   endtask

   // R9: idle read and no-access output
   task automatic t_idle();
      @(negedge clk); result = 12'h9E1; cs_n = 0; rd_n = 0;
      @(negedge clk);
      check(data_oe === 1'b1 && data_o === 12'h9E1, "R9 idle read", data_o, 12'h9E1);
      cs_n = 1;
      @(negedge clk);
      check(data_oe === 1'b0 && data_o === 12'h000, "R9 no select no drive", data_o, 0);
      rd_n = 1; cs_n = 0;
      @(negedge clk);
      check(data_oe === 1'b0 && data_o === 12'h000, "R9 select only no drive", data_o, 0);
      cs_n = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy_n === 1'b1 && wait_req === 1'b0 && data_oe === 1'b0, "R1 during reset",
            {busy_n, wait_req, data_oe}, 4);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      repeat (4) @(negedge clk);
      for (int w = 1; w <= 4; w++) begin t_busy_width(w); repeat (3) @(negedge clk); end
      for (int w = 1; w <= 4; w++) begin t_locked_read(w); repeat (3) @(negedge clk); end
      t_write_hold();
      t_open_read();
      set_lock(1'b0);
      t_locked_read(2);
      t_idle();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule